// File: doc/BRIEF.md
# Ordered-Key Information Access Gate

This block guards entry to a protected information region. It holds a single write-only 32-bit register at byte offset 0x40 of its small bus window. The access-enable level goes high only after software writes three fixed 32-bit keys to that register, one after another and in the correct order. Once the gate is open, the next write to the register closes it, whatever value that write carries. Reads of the register return zero in every state, so software cannot learn the progress of the sequence.

The enable output is a plain level. Other logic uses it to permit reads and writes of the protected region. Writes to other offsets in the window pass through without effect, and the sequence tracker keeps its progress while they happen.

Top module: `info_access_gate`

## Requirements
- R1: After the asynchronous active-low reset, access_en_o is 0, the tracker is at its starting step, and rdata_o is 0.
- R2: A write of 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 to byte offset 0x40 raises access_en_o on the clock edge that captures the third write.
- R3: A write to offset 0x40 that does not match the key expected at the current step sends the tracker back to its starting step, and access_en_o stays 0.
- R4: A mismatching write whose value equals 0x3A7F5CA3 counts as the first step of a new sequence.
- R5: While access_en_o is 1, any write to offset 0x40, including one carrying a key value, drops access_en_o on the edge that captures it. That write does not count as a sequence step.
- R6: rdata_o is 0 on the cycle after any read, whether the gate is open or closed.
- R7: Writes to any offset other than 0x40, reads, and idle cycles leave both the sequence progress and access_en_o unchanged.
- R8: The keys written out of order (for example the second or third key first) do not open the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, always zero |
| access_en_o | output | 1 | Protected-region access enable |

## Verification
A read and a write to the key register can arrive in the same cycle. This can happen as the third key lands, or as the relocking write lands. The bench drives both strobes together in those cycles and checks that the enable still moves exactly as the write alone dictates, while the read data stays zero. A relocking write that carries the first key also lands on the same edge as a potential sequence restart. The bench follows that write with the second and third keys and expects the gate to stay closed. Every output is compared each clock against a behavioural step counter.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h3A7F5CA3;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'hA1E34F20;
  localparam logic [DATA_W-1:0] KEY_THIRD  = 32'h9608B2C1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP1 = 2'd1,
    ST_STEP2 = 2'd2,
    ST_OPEN  = 2'd3
  } gate_state_e;
endpackage

// File: rtl/gate_addr_match.sv
module gate_addr_match #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_OFFSET = 'h40
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic sel;
  assign sel      = (addr_i == KEY_OFFSET);
  assign wr_hit_o = wr_en_i & sel;
  assign rd_hit_o = rd_en_i & sel;
endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
  import gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output gate_state_e       state_o,
  output logic              open_o
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_hit_i) begin
      if (state_q == ST_OPEN)
        state_d = ST_IDLE;              // any write relocks, never a step
      else if (wdata_i == KEY_FIRST)
        state_d = ST_STEP1;             // restart counts as step one
      else if (state_q == ST_STEP1 && wdata_i == KEY_SECOND)
        state_d = ST_STEP2;
      else if (state_q == ST_STEP2 && wdata_i == KEY_THIRD)
        state_d = ST_OPEN;
      else
        state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign open_o  = (state_q == ST_OPEN);
endmodule

// File: rtl/info_access_gate.sv
module info_access_gate
  import gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_OFFSET = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              access_en_o
);
  logic        wr_hit, rd_hit;
  gate_state_e state;
  logic [DATA_W-1:0] rdata_q;

  gate_addr_match #(.ADDR_W(ADDR_W), .KEY_OFFSET(KEY_OFFSET)) u_match (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  gate_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hit_i(wr_hit),
    .wdata_i (wdata_i),
    .state_o (state),
    .open_o  (access_en_o)
  );

  // write-only: the read path never exposes state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  logic unused_state;
  assign unused_state = ^state;
endmodule

// File: rtl/gate_checker.sv
module gate_checker
  import gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_OFFSET = 'h40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              access_en_o
);
  logic hit;
  assign hit = wr_en_i && (addr_i == KEY_OFFSET);

  a_r2_open_needs_third_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(access_en_o) |-> $past(hit && wdata_i == KEY_THIRD));

  a_r5_any_write_relocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_en_o && hit) |=> !access_en_o);

  a_r3_mismatch_stays_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_en_o && hit && wdata_i != KEY_THIRD) |=> !access_en_o);

  a_r7_no_hit_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(access_en_o));

  a_r6_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o == '0);
endmodule

bind info_access_gate gate_checker #(.ADDR_W(ADDR_W), .KEY_OFFSET(KEY_OFFSET)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .access_en_o(access_en_o)
);

// File: tb/sim_info_access_gate.sv
module sim_info_access_gate;
  localparam logic [31:0] K1 = 32'h3A7F5CA3;
  localparam logic [31:0] K2 = 32'hA1E34F20;
  localparam logic [31:0] K3 = 32'h9608B2C1;
  localparam logic [7:0]  OFS = 8'h40;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        en;
  int checks = 0, errors = 0, step = 0;

  always #10 clk = ~clk;

  info_access_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .access_en_o(en)
  );

  task automatic check(input string tag);
    logic exp_en;
    exp_en = (step == 3);
    checks++;
    if (en !== exp_en) begin
      errors++;
      $display("FAIL %s access_en_o actual=%0b expected=%0b", tag, en, exp_en);
    end
    checks++;
    if (rdata !== 32'h0) begin
      errors++;
      $display("FAIL %s rdata_o actual=%h expected=00000000", tag, rdata);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    if (w && a == OFS) begin
      if (step == 3)                  step = 0;
      else if (d == K1)               step = 1;
      else if (step == 1 && d == K2)  step = 2;
      else if (step == 2 && d == K3)  step = 3;
      else                            step = 0;
    end
    #1;
    wr = 0; rd = 0;
    check(tag);
  endtask

  task automatic key(input logic [31:0] d, input string tag);
    cyc(1, 0, OFS, d, tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35;
    check("R1");
    rst_n = 1;
    cyc(0, 1, OFS, 0, "R1");
    // R2 basic opening, third key with simultaneous read
    key(K1, "R2"); key(K2, "R2"); cyc(1, 1, OFS, K3, "R2");
    cyc(0, 1, OFS, 0, "R6");
    cyc(0, 0, 0, 0, "R7");
    // R7 other offsets while open
    cyc(1, 0, 8'h00, K1, "R7"); cyc(1, 0, 8'h44, 32'h0, "R7");
    // R5 relock with zero
    key(32'h0, "R5");
    // R5 relock carrying K1 plus read, then K2/K3 must not open
    key(K1, "R2"); key(K2, "R2"); key(K3, "R2");
    cyc(1, 1, OFS, K1, "R5"); key(K2, "R5"); key(K3, "R5");
    // R3 mismatches at each step
    key(K1, "R3"); key(32'h1234, "R3"); key(K2, "R3"); key(K3, "R3");
    key(K1, "R3"); key(K2, "R3"); key(K2, "R3"); key(K3, "R3");
    // R4 K1 as wrong value restarts at step one
    key(K1, "R4"); key(K2, "R4"); key(K1, "R4"); key(K2, "R4"); key(K3, "R4");
    key(32'hFFFF_FFFF, "R5");
    // R7 progress held across other traffic
    key(K1, "R7"); cyc(1, 0, 8'h44, K2, "R7"); cyc(0, 1, OFS, 0, "R7");
    cyc(0, 0, OFS, K3, "R7"); key(K2, "R7");
    cyc(1, 0, 8'h3C, 0, "R7"); cyc(0, 1, 8'h10, 0, "R7");
    key(K3, "R7");
    key(K3, "R5");
    // R8 out of order
    key(K2, "R8"); key(K3, "R8");
    key(K3, "R8"); key(K2, "R8"); key(K1, "R8");
    key(K2, "R8"); key(K1, "R8"); key(K3, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 1, OFS, 0, "R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule